// File: doc/BRIEF.md
# Remote Terminal Command Legality Filter

This block decides, for each decoded and valid command word received by a MIL-STD-1553B remote terminal, whether the terminal services the command or rejects it. A built-in rule set gives a default answer from the command fields. Those fields are the terminal address, the transmit/receive bit, the subaddress or mode field, and the word count or mode code. Mode commands are recognised by subaddress 0 or 31. Broadcast is terminal address 31. Two parameter masks let an integration mark individual data subaddresses as unsupported, one mask per direction.

When the override input is high as a command arrives, the block does not issue a verdict at once. It raises a request that carries the command fields and the default answer. It then waits for the subsystem to strobe back a legal or illegal answer, and that answer may reverse the default either way. If no answer comes within a programmable number of clocks, the default answer is used, so the terminal can still meet its response time. The message sequencer must not move data words until the single-cycle verdict pulse appears. A sticky message-error output feeds the status word. It is set by any rejected command. The next command clears it, unless that command is a "transmit status word" or "transmit last command" mode command, both of which must report the previous error.

Top module: `cmd_legality_filter`

## Requirements
- R1: After a synchronous active-low reset, verdict_valid, ovr_req and msg_error are all low.
- R2: With override off, the defined mode codes are legal by default when the T/R bit matches. Codes 0 to 8, 16, 18 and 19 need T/R=1. Codes 17, 20 and 21 need T/R=0.
- R3: A mode command whose code is reserved (9 to 15, 22 to 31) is illegal by default. So is a defined code whose T/R bit disagrees with the rule in R2.
- R4: For broadcast (address 31), a data command with T/R=1 is illegal. The mode codes that need a reply (0, 2, 16, 18, 19) are illegal. Broadcast receive data commands and the other defined mode codes with the correct T/R bit stay legal.
- R5: A data command to subaddress n is legal by default unless bit n of TX_ILLEGAL_SA (T/R=1) or RX_ILLEGAL_SA (T/R=0) is set.
- R6: With ovr_en low when cmd_valid is sampled, verdict_valid pulses for one cycle on the next cycle, carrying the default verdict, and ovr_req stays low.
- R7: With ovr_en high when cmd_valid is sampled, ovr_req is high from the next cycle, with ovr_cmd = {address, T/R, subaddress, word count} and ovr_dflt_legal = default verdict. It stays high, with no verdict, until an answer or a timeout.
- R8: An ovr_ack sampled while the request is pending ends it. On the next cycle verdict_valid pulses with verdict_service = ovr_legal, in either direction relative to the default.
- R9: If no answer comes, ovr_req stays high for exactly ovr_limit cycles (a limit of 0 acts as 1). The default verdict is then issued on the following cycle.
- R10: msg_error is set together with any reject verdict. An accepted command clears it, unless that command is mode code 2 or 18 (subaddress 0 or 31), which keeps it.
- R11: A new cmd_valid while a request is pending replaces the pending command, and the old command gets no verdict. An ovr_ack with no pending request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe: decoded valid command present |
| cmd_rt_addr | input | 5 | Terminal address field (31 = broadcast) |
| cmd_tx | input | 1 | Transmit/receive bit (1 = terminal transmits) |
| cmd_sa | input | 5 | Subaddress or mode field (0 or 31 = mode command) |
| cmd_wc | input | 5 | Word count or mode code field |
| ovr_en | input | 1 | Subsystem override enabled for this command |
| ovr_limit | input | TW | Answer wait limit in clocks |
| ovr_ack | input | 1 | Subsystem answer strobe |
| ovr_legal | input | 1 | Subsystem answer: 1 = service, 0 = reject |
| ovr_req | output | 1 | Override request pending |
| ovr_cmd | output | 16 | Fields of the pending command |
| ovr_dflt_legal | output | 1 | Default verdict of the pending command |
| verdict_valid | output | 1 | One-cycle final verdict pulse |
| verdict_service | output | 1 | Final verdict: 1 = service, 0 = reject |
| msg_error | output | 1 | Message-error bit for the status word |

## Verification
The bench builds the block with TW = 8, TX_ILLEGAL_SA marking only subaddress 8 and RX_ILLEGAL_SA marking only subaddress 9. The masks make one rejected and one accepted subaddress available in each direction, next to an untouched one. The 8-bit limit lets the timeout path run at a limit of 5 and at the degenerate limit of 0 within a few cycles. The limit of 8 used elsewhere leaves room for an answer to come after several cycles of waiting.

// File: rtl/cmdf_pkg.sv
// Package cmdf_pkg
// Shared field widths, the command record and the mode code rule set of the
// command legality filter. Assumes the standard 5-bit field layout.
package cmdf_pkg;

    localparam int ADDR_W = 5;
    localparam int SA_W   = 5;
    localparam int WC_W   = 5;
    localparam int CMD_W  = ADDR_W + 1 + SA_W + WC_W;
    localparam int SA_N   = 1 << SA_W;

    localparam logic [ADDR_W-1:0] BCAST_ADDR = '1;
    localparam logic [SA_W-1:0]   MODE_SA_A  = '0;
    localparam logic [SA_W-1:0]   MODE_SA_B  = '1;

    typedef struct packed {
        logic [ADDR_W-1:0] rt;
        logic              tx;
        logic [SA_W-1:0]   sa;
        logic [WC_W-1:0]   wc;
    } cmd_t;

    typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} seq_st_t;

    // True for mode codes that have a defined meaning.
    function automatic logic mode_known(input logic [WC_W-1:0] code);
        return (code inside {[5'd0:5'd8], [5'd16:5'd21]});
    endfunction

    // Required T/R bit of a defined mode code.
    function automatic logic mode_dir(input logic [WC_W-1:0] code);
        return !(code inside {5'd17, 5'd20, 5'd21});
    endfunction

    // Defined mode codes that may be broadcast (no reply is needed).
    function automatic logic mode_bcast_ok(input logic [WC_W-1:0] code);
        return (code inside {5'd1, [5'd3:5'd8], 5'd17, 5'd20, 5'd21});
    endfunction

    // Mode codes that report on the previous message and so keep its error.
    function automatic logic mode_keeps_err(input logic [WC_W-1:0] code);
        return (code inside {5'd2, 5'd18});
    endfunction

endpackage

// File: rtl/cmdf_rules.sv
// Module cmdf_rules
// Combinational default legality of one command word. Assumes the command
// is already known valid (sync, parity and address match done upstream).
module cmdf_rules
    import cmdf_pkg::*;
#(
    parameter logic [SA_N-1:0] TX_ILLEGAL_SA = '0,
    parameter logic [SA_N-1:0] RX_ILLEGAL_SA = '0
) (
    input  cmd_t cmd,
    output logic dflt_legal,
    output logic keeps_err
);

    logic is_mode;
    logic is_bcast;
    logic mode_ok;
    logic data_ok;
    logic [SA_N-1:0] sa_block;

    // Per-direction subaddress blocking mask, one bit per subaddress.
    for (genvar g = 0; g < SA_N; g++) begin : g_sa_mask
        assign sa_block[g] = cmd.tx ? TX_ILLEGAL_SA[g] : RX_ILLEGAL_SA[g];
    end

    // Classify the command and apply the mode and data rule sets.
    always_comb begin
        is_mode    = (cmd.sa == MODE_SA_A) || (cmd.sa == MODE_SA_B);
        is_bcast   = (cmd.rt == BCAST_ADDR);
        mode_ok    = mode_known(cmd.wc) && (cmd.tx == mode_dir(cmd.wc))
                     && (!is_bcast || mode_bcast_ok(cmd.wc));
        data_ok    = !(is_bcast && cmd.tx) && !sa_block[cmd.sa];
        dflt_legal = is_mode ? mode_ok : data_ok;
        keeps_err  = is_mode && mode_keeps_err(cmd.wc);
    end

endmodule

// File: rtl/cmdf_timer.sv
// Module cmdf_timer
// Answer wait counter. Loaded with the limit when a command is accepted,
// counts down while the request is pending, flags the last waiting cycle.
// A limit of 0 behaves as 1. Assumes load and run are never needed at once.
module cmdf_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] limit,
    input  logic          run,
    output logic          expired
);

    logic [TW-1:0] cnt;

    // Load on accept, then saturating count-down while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= limit;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Last waiting cycle: remaining count of one or zero.
    assign expired = run && (cnt <= TW'(1));

endmodule

// File: rtl/cmdf_seq.sv
// Module cmdf_seq
// Verdict sequencer. Accepts a command, either issues its default verdict
// at once or holds an override request until an answer or timeout, and
// keeps the sticky message-error bit. A new command always wins.
module cmdf_seq
    import cmdf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  cmd_t cmd_in,
    input  logic dflt_in,
    input  logic keep_in,
    input  logic ovr_en,
    input  logic ovr_ack,
    input  logic ovr_legal,
    input  logic expired,
    output logic waiting,
    output cmd_t cmd_q,
    output logic dflt_q,
    output logic verdict_valid,
    output logic verdict_service,
    output logic msg_error
);

    seq_st_t st, st_n;
    logic    vv_n, vs_n, me_n, me_base;

    // Next-state, verdict and error-bit decision for this cycle.
    always_comb begin
        st_n    = st;
        vv_n    = 1'b0;
        vs_n    = verdict_service;
        me_n    = msg_error;
        me_base = keep_in ? msg_error : 1'b0;
        if (cmd_valid) begin
            me_n = me_base;
            if (ovr_en) begin
                st_n = ST_WAIT;
            end else begin
                st_n = ST_IDLE;
                vv_n = 1'b1;
                vs_n = dflt_in;
                if (!dflt_in) me_n = 1'b1;
            end
        end else if (st == ST_WAIT) begin
            if (ovr_ack) begin
                st_n = ST_IDLE;
                vv_n = 1'b1;
                vs_n = ovr_legal;
                if (!ovr_legal) me_n = 1'b1;
            end else if (expired) begin
                st_n = ST_IDLE;
                vv_n = 1'b1;
                vs_n = dflt_q;
                if (!dflt_q) me_n = 1'b1;
            end
        end
    end

    // State, verdict and error registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st              <= ST_IDLE;
            verdict_valid   <= 1'b0;
            verdict_service <= 1'b0;
            msg_error       <= 1'b0;
        end else begin
            st              <= st_n;
            verdict_valid   <= vv_n;
            verdict_service <= vs_n;
            msg_error       <= me_n;
        end
    end

    // Capture of the accepted command and its default verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            dflt_q <= 1'b0;
        end else if (cmd_valid) begin
            cmd_q  <= cmd_in;
            dflt_q <= dflt_in;
        end
    end

    assign waiting = (st == ST_WAIT);

    // R6
    off_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !ovr_en) |=> (verdict_valid && verdict_service == $past(dflt_in)));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !ovr_ack && !expired && !cmd_valid) |=> (waiting && !verdict_valid));

    // R8
    answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && ovr_ack && !cmd_valid) |=> (verdict_valid && verdict_service == $past(ovr_legal)));

    // R9
    timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && !ovr_ack && expired && !cmd_valid) |=> (verdict_valid && verdict_service == $past(dflt_q)));

    // R11
    ack_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!waiting && !cmd_valid) |=> !verdict_valid);

endmodule

// File: rtl/cmd_legality_filter.sv
// Module cmd_legality_filter
// Top of the remote terminal command legality filter: default rules,
// answer wait timer and verdict sequencer. Assumes cmd_valid is a one-cycle
// strobe from the command decoder and the fields are valid with it.
module cmd_legality_filter
    import cmdf_pkg::*;
#(
    parameter int              TW            = 8,
    parameter logic [SA_N-1:0] TX_ILLEGAL_SA = '0,
    parameter logic [SA_N-1:0] RX_ILLEGAL_SA = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_rt_addr,
    input  logic              cmd_tx,
    input  logic [SA_W-1:0]   cmd_sa,
    input  logic [WC_W-1:0]   cmd_wc,
    input  logic              ovr_en,
    input  logic [TW-1:0]     ovr_limit,
    input  logic              ovr_ack,
    input  logic              ovr_legal,
    output logic              ovr_req,
    output logic [CMD_W-1:0]  ovr_cmd,
    output logic              ovr_dflt_legal,
    output logic              verdict_valid,
    output logic              verdict_service,
    output logic              msg_error
);

    cmd_t cmd_in, cmd_q;
    logic dflt_in, keep_in, expired, waiting;

    assign cmd_in = '{rt: cmd_rt_addr, tx: cmd_tx, sa: cmd_sa, wc: cmd_wc};

    cmdf_rules #(
        .TX_ILLEGAL_SA (TX_ILLEGAL_SA),
        .RX_ILLEGAL_SA (RX_ILLEGAL_SA)
    ) u_rules (
        .cmd        (cmd_in),
        .dflt_legal (dflt_in),
        .keeps_err  (keep_in)
    );

    cmdf_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cmd_valid),
        .limit   (ovr_limit),
        .run     (waiting),
        .expired (expired)
    );

    cmdf_seq u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .cmd_valid       (cmd_valid),
        .cmd_in          (cmd_in),
        .dflt_in         (dflt_in),
        .keep_in         (keep_in),
        .ovr_en          (ovr_en),
        .ovr_ack         (ovr_ack),
        .ovr_legal       (ovr_legal),
        .expired         (expired),
        .waiting         (waiting),
        .cmd_q           (cmd_q),
        .dflt_q          (ovr_dflt_legal),
        .verdict_valid   (verdict_valid),
        .verdict_service (verdict_service),
        .msg_error       (msg_error)
    );

    assign ovr_req = waiting;
    assign ovr_cmd = cmd_q;

    // R10
    reject_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && !verdict_service) |-> msg_error);

    // R10
    accept_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && ovr_en && !keep_in) |=> !msg_error);

    // R7
    no_verdict_while_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_req |-> !verdict_valid);

endmodule

// File: tb/cmd_legality_filter_tb.sv
module cmd_legality_filter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TW = 8;

    typedef struct {
        logic  svc;
        logic  me;
        string tag;
    } exp_t;

    logic clk, rst_n, cmd_valid, cmd_tx, ovr_en, ovr_ack, ovr_legal;
    logic [4:0] cmd_rt_addr, cmd_sa, cmd_wc;
    logic [TW-1:0] ovr_limit;
    logic ovr_req, ovr_dflt_legal, verdict_valid, verdict_service, msg_error;
    logic [15:0] ovr_cmd;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    logic exp_me = 1'b0;

    cmd_legality_filter #(
        .TW            (TW),
        .TX_ILLEGAL_SA (32'h0000_0100),
        .RX_ILLEGAL_SA (32'h0000_0200)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rt_addr(cmd_rt_addr),
        .cmd_tx(cmd_tx), .cmd_sa(cmd_sa), .cmd_wc(cmd_wc), .ovr_en(ovr_en),
        .ovr_limit(ovr_limit), .ovr_ack(ovr_ack), .ovr_legal(ovr_legal),
        .ovr_req(ovr_req), .ovr_cmd(ovr_cmd), .ovr_dflt_legal(ovr_dflt_legal),
        .verdict_valid(verdict_valid), .verdict_service(verdict_service),
        .msg_error(msg_error)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: pop the scoreboard on each verdict pulse.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && verdict_valid) begin
            if (sb.size() == 0) begin
                check(0, "R11", "unexpected verdict", 1, 0);
            end else begin
                e = sb.pop_front();
                check(verdict_service == e.svc, e.tag, "verdict_service", verdict_service, e.svc);
                check(msg_error == e.me, e.tag, "msg_error", msg_error, e.me);
            end
        end
    end

    // Driver: act 0 = no answer, 1 = answer legal, 2 = answer illegal.
    task automatic run_cmd(input logic [4:0] rt, input logic tx, input logic [4:0] sa,
                           input logic [4:0] wc, input logic en, input logic dflt,
                           input int act, input int dly, input logic [TW-1:0] lim,
                           input string tag);
        logic keep, svc;
        int   reqc, expc;
        keep = (sa == 5'd0 || sa == 5'd31) && (wc == 5'd2 || wc == 5'd18);
        if (!keep) exp_me = 1'b0;
        svc = (!en || act == 0) ? dflt : (act == 1);
        if (!svc) exp_me = 1'b1;
        sb.push_back('{svc: svc, me: exp_me, tag: tag});
        cmd_rt_addr = rt; cmd_tx = tx; cmd_sa = sa; cmd_wc = wc;
        ovr_en = en; ovr_limit = lim; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (!en) begin
            check(!ovr_req, "R6", "ovr_req", ovr_req, 0);
        end else begin
            check(ovr_req, "R7", "ovr_req", ovr_req, 1);
            check(ovr_cmd == {rt, tx, sa, wc}, "R7", "ovr_cmd", ovr_cmd, {rt, tx, sa, wc});
            check(ovr_dflt_legal == dflt, tag, "ovr_dflt_legal", ovr_dflt_legal, dflt);
            if (act == 0) begin
                reqc = 0;
                while (ovr_req && reqc < 300) begin
                    reqc++;
                    @(negedge clk);
                end
                expc = (lim == 0) ? 1 : int'(lim);
                check(reqc == expc, "R9", "request cycles", reqc, expc);
            end else begin
                for (int i = 0; i < dly; i++) begin
                    check(ovr_req && !verdict_valid, "R7", "held without verdict",
                          verdict_valid, 0);
                    @(negedge clk);
                end
                ovr_ack = 1'b1;
                ovr_legal = (act == 1);
                @(negedge clk);
                ovr_ack = 1'b0;
                check(!ovr_req, "R8", "request dropped", ovr_req, 0);
            end
        end
        @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_tx = 1'b0; ovr_en = 1'b0;
        ovr_ack = 1'b0; ovr_legal = 1'b0; cmd_rt_addr = 5'd0; cmd_sa = 5'd0;
        cmd_wc = 5'd0; ovr_limit = 8'd8;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!verdict_valid, "R1", "verdict_valid", verdict_valid, 0);
        check(!ovr_req, "R1", "ovr_req", ovr_req, 0);
        check(!msg_error, "R1", "msg_error", msg_error, 0);

        // R2 defined mode codes
        run_cmd(5'd5, 1'b1, 5'd0,  5'd2,  1'b0, 1'b1, 0, 0, 8'd8, "R2");
        run_cmd(5'd5, 1'b0, 5'd31, 5'd17, 1'b0, 1'b1, 0, 0, 8'd8, "R2");
        run_cmd(5'd5, 1'b0, 5'd0,  5'd20, 1'b0, 1'b1, 0, 0, 8'd8, "R2");
        // R3 reserved codes and direction mismatch
        run_cmd(5'd5, 1'b1, 5'd0,  5'd12, 1'b0, 1'b0, 0, 0, 8'd8, "R3");
        run_cmd(5'd5, 1'b0, 5'd31, 5'd25, 1'b0, 1'b0, 0, 0, 8'd8, "R3");
        run_cmd(5'd5, 1'b1, 5'd0,  5'd17, 1'b0, 1'b0, 0, 0, 8'd8, "R3");
        run_cmd(5'd5, 1'b0, 5'd0,  5'd4,  1'b0, 1'b0, 0, 0, 8'd8, "R3");
        // R10 transmit status keeps the error, next command clears it
        run_cmd(5'd5, 1'b1, 5'd0,  5'd2,  1'b0, 1'b1, 0, 0, 8'd8, "R10");
        check(msg_error, "R10", "kept by mode 2", msg_error, 1);
        run_cmd(5'd5, 1'b0, 5'd3,  5'd4,  1'b0, 1'b1, 0, 0, 8'd8, "R10");
        check(!msg_error, "R10", "cleared", msg_error, 0);
        // R4 broadcast
        run_cmd(5'd31, 1'b1, 5'd3,  5'd4,  1'b0, 1'b0, 0, 0, 8'd8, "R4");
        run_cmd(5'd31, 1'b0, 5'd3,  5'd4,  1'b0, 1'b1, 0, 0, 8'd8, "R4");
        run_cmd(5'd31, 1'b1, 5'd0,  5'd2,  1'b0, 1'b0, 0, 0, 8'd8, "R4");
        run_cmd(5'd31, 1'b1, 5'd31, 5'd1,  1'b0, 1'b1, 0, 0, 8'd8, "R4");
        run_cmd(5'd31, 1'b0, 5'd0,  5'd17, 1'b0, 1'b1, 0, 0, 8'd8, "R4");
        // R5 subaddress masks
        run_cmd(5'd5, 1'b1, 5'd8, 5'd3, 1'b0, 1'b0, 0, 0, 8'd8, "R5");
        run_cmd(5'd5, 1'b0, 5'd8, 5'd3, 1'b0, 1'b1, 0, 0, 8'd8, "R5");
        run_cmd(5'd5, 1'b0, 5'd9, 5'd3, 1'b0, 1'b0, 0, 0, 8'd8, "R5");
        run_cmd(5'd5, 1'b1, 5'd9, 5'd3, 1'b0, 1'b1, 0, 0, 8'd8, "R5");
        run_cmd(5'd5, 1'b1, 5'd4, 5'd3, 1'b0, 1'b1, 0, 0, 8'd8, "R5");
        // R8 override in both directions
        run_cmd(5'd5, 1'b0, 5'd4, 5'd3,  1'b1, 1'b1, 2, 2, 8'd8, "R8");
        run_cmd(5'd5, 1'b1, 5'd0, 5'd12, 1'b1, 1'b0, 1, 0, 8'd8, "R8");
        run_cmd(5'd5, 1'b1, 5'd0, 5'd13, 1'b1, 1'b0, 1, 5, 8'd8, "R8");
        // R9 timeout
        run_cmd(5'd5, 1'b1, 5'd0, 5'd12, 1'b1, 1'b0, 0, 0, 8'd5, "R9");
        run_cmd(5'd5, 1'b0, 5'd4, 5'd3,  1'b1, 1'b1, 0, 0, 8'd0, "R9");

        // R11 superseding command: the first never gets a verdict
        cmd_rt_addr = 5'd5; cmd_tx = 1'b0; cmd_sa = 5'd4; cmd_wc = 5'd3;
        ovr_en = 1'b1; ovr_limit = 8'd8; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        exp_me = 1'b0;
        check(ovr_req, "R11", "first request", ovr_req, 1);
        run_cmd(5'd5, 1'b1, 5'd8, 5'd3, 1'b0, 1'b0, 0, 0, 8'd8, "R11");
        check(!ovr_req, "R11", "old request dropped", ovr_req, 0);
        repeat (10) @(negedge clk);

        // R11 stray answer with nothing pending
        ovr_ack = 1'b1; ovr_legal = 1'b1;
        @(negedge clk);
        ovr_ack = 1'b0;
        check(!verdict_valid, "R11", "stray ack verdict", verdict_valid, 0);
        check(msg_error == exp_me, "R11", "stray ack msg_error", msg_error, exp_me);
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R11", "pending expectations", sb.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule